// File: doc/BRIEF.md
# Float32 normalize-round-pack unit

This block turns an unpacked single-precision intermediate value into a finished IEEE-754 binary32 word and a set of exception flags. The intermediate value has a sign, a signed exponent and a 32-bit significand. The significand carries guard and sticky information below the mantissa. An arithmetic datapath (adder, multiplier, divider or converter) produces this intermediate. The unit then does the last steps that every such operation shares: it normalizes, denormalizes tiny values with a sticky shift, rounds in one of four modes, detects rounding carry-out, saturates on overflow, and packs the word.

The internal exponent is one less than the biased exponent field of a normal result. This is because packing adds the significand's leading one into the exponent field. An operand equal to 1.0 is therefore presented as significand 1 with exponent 157, or as significand 0x80000000 with exponent 126. A request is accepted whenever `in_valid` is high. The result and flags appear registered one clock later, with `out_valid`.

Top module: `fnr_unit`

## Requirements
- R1: When the exponent input equals 255 and either the significand is zero or any incoming flag is set, the value skips rounding. The output is the sign in bit 31 and the 31-bit sum of (255 << 23) and (significand >> 7). The flags equal the incoming flags. Exponent 255 with a zero significand gives a signed infinity, 0x7F800000.
- R2: Outside R1, a zero significand yields a signed zero: bit 31 is the sign and every other bit is 0. The flags are passed through unchanged.
- R3: A nonzero significand is shifted left until bit 31 is set, and the exponent is lowered by the shift count. Significand 1 with exponent 157 in nearest mode gives 0x3F800000 with no new flag.
- R4: If the normalized exponent is negative, the significand is shifted right by its magnitude. Every bit shifted out is ORed into bit 0, and the exponent becomes 0. This value is an underflow candidate only if bits [7:0] are then nonzero.
- R5: Rounding mode 00 (nearest) adds 0x80 when significand bit 8 is 1 and 0x7F when it is 0, so ties go to the even mantissa.
- R6: Mode 11 (toward zero) adds 0. Mode 01 (toward +inf) adds 0xFF for a positive sign and 0 for a negative sign. Mode 10 (toward -inf) adds 0xFF for a negative sign and 0 for a positive sign.
- R7: If adding the increment carries out of 32 bits, the following happens before the add: the exponent is raised by one, the significand is shifted right by one with its old bit 0 kept ORed in, and the increment is halved.
- R8: The inexact flag (bit 4) is set when significand bits [7:0] are nonzero before the increment is added. It is also set on every overflow.
- R9: If the exponent is 254 or more at rounding, the overflow (bit 2) and inexact flags are set. The magnitude is 0x7F7FFFFF when the increment is zero and 0x7F800000 otherwise.
- R10: If the rounded significand has no bit set above bit 7, the exponent becomes 0. The underflow flag (bit 3) is raised only for an R4 candidate that still has a zero exponent and a rounded significand of at most 0x80000000. Otherwise the output is sign | ((exponent << 23) + (rounded significand >> 8)).
- R11: The flag vector is {inexact, underflow, overflow, divide-by-zero, invalid}, from bit 4 down to bit 0. The output flags are the incoming flags ORed with any new ones.
- R12: `out_valid` is high exactly in the cycle after an accepted `in_valid`. Result and flags change only then and hold otherwise. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Intermediate value present this cycle |
| sign_in | input | 1 | Sign of the intermediate value |
| exp_in | input | EXP_W | Signed internal exponent |
| sig_in | input | 32 | Significand with 8 bits below the mantissa |
| rmode_in | input | 2 | Rounding mode: 00 nearest, 01 +inf, 10 -inf, 11 zero |
| flags_in | input | 5 | Flags already raised by the producing operation |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Packed binary32 word |
| flags_out | output | 5 | Incoming flags ORed with rounding flags |

## Verification
A sweep crosses internal exponents from deep in the tiny range, through the normal range, past the overflow threshold and up to the special exponent 255. These exponents are paired with significands chosen to split the cases: a lone low bit, an exact tie below and above an even mantissa, a pure sticky tail, an all-ones value that carries out of rounding, and zero. Each combination runs under all four modes and both signs, so that directed modes are told apart from their mirror images. Directed vectors pin hand-computed words for ties to even, carry-out to the next power of two, the smallest subnormal with and without the underflow flag, rounding up to the smallest normal, and infinity versus largest finite on overflow.

// File: rtl/fnr_pkg.sv
package fnr_pkg;

    localparam int SIG_W  = 32;          // significand width of the intermediate
    localparam int DROP_W = 8;           // bits discarded below the mantissa LSB
    localparam int EF_W   = 8;           // packed exponent field width
    localparam int MAN_W  = 23;          // packed mantissa width
    localparam int FLG_W  = 5;           // flag vector width
    localparam int SHF_W  = $clog2(SIG_W);

    localparam int EXP_SPECIAL = 255;    // infinity / NaN exponent
    localparam int EXP_OVF     = 254;    // first exponent that overflows
    localparam int EXP_MAXFIN  = 253;    // internal exponent of largest finite

    // flag bit positions
    localparam int FB_IXC = 4;
    localparam int FB_UFC = 3;
    localparam int FB_OFC = 2;
    localparam int FB_DZC = 1;
    localparam int FB_IOC = 0;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_UP      = 2'b01,
        RM_DOWN    = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_t;

endpackage

// File: rtl/fnr_norm.sv
module fnr_norm
    import fnr_pkg::*;
#(
    parameter int EXP_W = 12
) (
    input  logic [SIG_W-1:0]        sig_i,
    input  logic signed [EXP_W-1:0] exp_i,
    output logic [SIG_W-1:0]        sig_o,
    output logic signed [EXP_W-1:0] exp_o,
    output logic                    uf_cand_o
);

    localparam int CNT_W = SHF_W + 1;

    logic [CNT_W-1:0]        lead_zeros;
    logic                    seen_one;
    logic [SIG_W-1:0]        shifted;
    logic signed [EXP_W-1:0] norm_exp;
    logic [EXP_W-1:0]        right_amt;
    logic [SHF_W-1:0]        right_sh;
    logic [SIG_W-1:0]        lost_bits;
    logic                    is_tiny;

    // leading-zero count, priority from the top bit
    always_comb begin
        lead_zeros = '0;
        seen_one   = 1'b0;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            if (!seen_one) begin
                if (sig_i[i]) begin
                    seen_one = 1'b1;
                end else begin
                    lead_zeros = lead_zeros + 1'b1;
                end
            end
        end
    end

    always_comb begin
        shifted   = sig_i << lead_zeros;
        norm_exp  = exp_i - EXP_W'(lead_zeros);
        is_tiny   = norm_exp[EXP_W-1];
        right_amt = EXP_W'(-norm_exp);
        right_sh  = right_amt[SHF_W-1:0];
        lost_bits = '0;
        sig_o     = shifted;
        exp_o     = norm_exp;
        if (is_tiny) begin
            exp_o = '0;
            if (right_amt >= EXP_W'(SIG_W)) begin
                sig_o = {{(SIG_W-1){1'b0}}, |shifted};
            end else begin
                lost_bits = shifted << (SIG_W - int'(right_sh));
                sig_o     = (shifted >> right_sh) | SIG_W'(|lost_bits);
            end
        end
        uf_cand_o = is_tiny && (|sig_o[DROP_W-1:0]);
    end

endmodule

// File: rtl/fnr_round.sv
module fnr_round
    import fnr_pkg::*;
#(
    parameter int EXP_W = 12
) (
    input  logic                    sign_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0]        sig_i,
    input  logic                    uf_cand_i,
    input  rmode_t                  mode_i,
    output logic [EF_W-1:0]         exp_o,
    output logic [SIG_W-1:0]        sig_o,
    output logic [FLG_W-1:0]        flags_o
);

    localparam logic signed [EXP_W-1:0] OVF_EXP = EXP_W'(EXP_OVF);
    localparam logic [SIG_W-1:0] HALF_ULP = SIG_W'(1) << (DROP_W - 1);
    localparam logic [SIG_W-1:0] FULL_ULP = (SIG_W'(1) << DROP_W) - 1'b1;
    localparam logic [SIG_W-1:0] SIG_MID  = SIG_W'(1) << (SIG_W - 1);

    logic [SIG_W-1:0]        incr;
    logic [SIG_W-1:0]        incr_adj;
    logic [SIG_W:0]          trial;
    logic                    carry;
    logic signed [EXP_W-1:0] exp_adj;
    logic signed [EXP_W-1:0] exp_fin;
    logic [SIG_W-1:0]        sig_adj;
    logic [SIG_W-1:0]        sig_rnd;
    logic                    inexact;
    logic                    uf_keep;

    // increment selection per mode
    always_comb begin
        incr = '0;
        unique case (mode_i)
            RM_NEAREST: incr = sig_i[DROP_W] ? HALF_ULP : HALF_ULP - 1'b1;
            RM_UP:      incr = sign_i ? '0 : FULL_ULP;
            RM_DOWN:    incr = sign_i ? FULL_ULP : '0;
            RM_ZERO:    incr = '0;
            default:    incr = '0;
        endcase
    end

    always_comb begin
        trial = {1'b0, sig_i} + {1'b0, incr};
        carry = trial[SIG_W];
        if (carry) begin
            exp_adj  = exp_i + EXP_W'(1);
            sig_adj  = (sig_i >> 1) | {{(SIG_W-1){1'b0}}, sig_i[0]};
            incr_adj = incr >> 1;
        end else begin
            exp_adj  = exp_i;
            sig_adj  = sig_i;
            incr_adj = incr;
        end
        inexact = |sig_adj[DROP_W-1:0];
        sig_rnd = sig_adj + incr_adj;
        flags_o = '0;
        exp_fin = exp_adj;
        uf_keep = uf_cand_i;
        if (exp_adj >= OVF_EXP) begin
            flags_o[FB_OFC] = 1'b1;
            flags_o[FB_IXC] = 1'b1;
            if (incr_adj == '0) begin
                exp_o = EF_W'(EXP_MAXFIN);
                sig_o = {1'b0, {(SIG_W-1){1'b1}}};
            end else begin
                exp_o = EF_W'(EXP_SPECIAL);
                sig_o = '0;
            end
        end else begin
            if (sig_rnd[SIG_W-1:DROP_W] == '0) begin
                exp_fin = '0;
            end
            if ((exp_fin != '0) || (sig_rnd > SIG_MID)) begin
                uf_keep = 1'b0;
            end
            flags_o[FB_IXC] = inexact;
            flags_o[FB_UFC] = uf_keep;
            exp_o = EF_W'(exp_fin);
            sig_o = sig_rnd >> 1;
        end
    end

endmodule

// File: rtl/fnr_pack.sv
module fnr_pack
    import fnr_pkg::*;
(
    input  logic             sign_i,
    input  logic [EF_W-1:0]  exp_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic [SIG_W-1:0] word_o
);

    localparam int LOW_SH = DROP_W - 1;

    logic [SIG_W-2:0] body;

    // additive pack: the leading one of the significand bumps the field
    always_comb begin
        body   = {exp_i, {MAN_W{1'b0}}} + (SIG_W-1)'(sig_i >> LOW_SH);
        word_o = {sign_i, body};
    end

endmodule

// File: rtl/fnr_unit.sv
module fnr_unit
    import fnr_pkg::*;
#(
    parameter int EXP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    sign_in,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic [31:0]             sig_in,
    input  logic [1:0]              rmode_in,
    input  logic [4:0]              flags_in,
    output logic                    out_valid,
    output logic [31:0]             result,
    output logic [4:0]              flags_out
);

    typedef struct packed {
        logic             vld;
        logic [SIG_W-1:0] word;
        logic [FLG_W-1:0] flg;
    } stage_t;

    stage_t st_d, st_q;

    logic [SIG_W-1:0]        n_sig;
    logic signed [EXP_W-1:0] n_exp;
    logic                    n_uf;
    logic [EF_W-1:0]         r_exp;
    logic [SIG_W-1:0]        r_sig;
    logic [FLG_W-1:0]        r_flags;
    logic                    take_bypass;
    logic                    take_zero;
    logic [EF_W-1:0]         p_exp;
    logic [SIG_W-1:0]        p_sig;
    logic [FLG_W-1:0]        p_flags;
    logic [SIG_W-1:0]        p_word;

    fnr_norm #(.EXP_W(EXP_W)) i_norm (
        .sig_i     (sig_in),
        .exp_i     (exp_in),
        .sig_o     (n_sig),
        .exp_o     (n_exp),
        .uf_cand_o (n_uf)
    );

    fnr_round #(.EXP_W(EXP_W)) i_round (
        .sign_i    (sign_in),
        .exp_i     (n_exp),
        .sig_i     (n_sig),
        .uf_cand_i (n_uf),
        .mode_i    (rmode_t'(rmode_in)),
        .exp_o     (r_exp),
        .sig_o     (r_sig),
        .flags_o   (r_flags)
    );

    fnr_pack i_pack (
        .sign_i (sign_in),
        .exp_i  (p_exp),
        .sig_i  (p_sig),
        .word_o (p_word)
    );

    // path select
    always_comb begin
        take_bypass = (exp_in == EXP_W'(EXP_SPECIAL)) &&
                      ((sig_in == '0) || (flags_in != '0));
        take_zero   = (sig_in == '0);
        if (take_bypass) begin
            p_exp   = EF_W'(EXP_SPECIAL);
            p_sig   = sig_in;
            p_flags = flags_in;
        end else if (take_zero) begin
            p_exp   = '0;
            p_sig   = '0;
            p_flags = flags_in;
        end else begin
            p_exp   = r_exp;
            p_sig   = r_sig;
            p_flags = flags_in | r_flags;
        end
    end

    // next state
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.word = p_word;
            st_d.flg  = p_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.word;
    assign flags_out = st_q.flg;

endmodule

// File: rtl/fnr_unit_chk.sv
module fnr_unit_chk
    import fnr_pkg::*;
#(
    parameter int EXP_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    sign_in,
    input logic signed [EXP_W-1:0] exp_in,
    input logic [31:0]             sig_in,
    input logic [4:0]              flags_in,
    input logic                    out_valid,
    input logic [31:0]             result,
    input logic [4:0]              flags_out
);

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(flags_out));

    // R11
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((flags_out & $past(flags_in)) == $past(flags_in)));

    // R2
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sig_in == '0 && exp_in != EXP_W'(EXP_SPECIAL))
        |=> (result[30:0] == '0) && (flags_out == $past(flags_in)));

    // R1
    inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sig_in == '0 && exp_in == EXP_W'(EXP_SPECIAL))
        |=> (result[30:0] == 31'h7F800000));

    // R9
    ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flags_in[FB_OFC])
        |=> (!flags_out[FB_OFC] || result[30:0] == 31'h7F800000 ||
             result[30:0] == 31'h7F7FFFFF));

    // R10
    unf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flags_in[FB_UFC])
        |=> (!flags_out[FB_UFC] || result[30:23] == 8'h00 ||
             result[30:0] == 31'h00800000));

    // R8
    ixc_with_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flags_in == '0)
        |=> (!(flags_out[FB_UFC] || flags_out[FB_OFC]) || flags_out[FB_IXC]));

    // R3
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (result[31] == $past(sign_in)));

endmodule

bind fnr_unit fnr_unit_chk #(.EXP_W(EXP_W)) i_fnr_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sign_in   (sign_in),
    .exp_in    (exp_in),
    .sig_in    (sig_in),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/test_fnr_unit.sv
module test_fnr_unit;

    localparam int EXP_W = 12;
    localparam int WATCH_CYCLES = 190000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    sign_in = 1'b0;
    logic signed [EXP_W-1:0] exp_in = '0;
    logic [31:0]             sig_in = '0;
    logic [1:0]              rmode_in = 2'b00;
    logic [4:0]              flags_in = '0;
    logic                    out_valid;
    logic [31:0]             result;
    logic [4:0]              flags_out;

    int  errors = 0;
    int  checks = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fnr_unit #(.EXP_W(EXP_W)) i_fnr_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sign_in   (sign_in),
        .exp_in    (exp_in),
        .sig_in    (sig_in),
        .rmode_in  (rmode_in),
        .flags_in  (flags_in),
        .out_valid (out_valid),
        .result    (result),
        .flags_out (flags_out)
    );

    function automatic bit [31:0] pack_word(bit s, longint e, longint v);
        longint body;
        body = ((e << 23) + (v >> 7)) & 64'h7FFFFFFF;
        return {s, body[30:0]};
    endfunction

    // arithmetic reference built from the requirements
    task automatic ref_model(input bit s, input int e, input bit [31:0] m,
                             input bit [1:0] md, input bit [4:0] fi,
                             output bit [31:0] r, output bit [4:0] fo,
                             output string tag);
        longint sig;
        longint inc;
        int     ex;
        bit     uf;
        bit     ix;
        bit     lost;
        if (e == 255 && (m == 0 || fi != 0)) begin
            r = pack_word(s, 255, longint'(m)); fo = fi; tag = "R1"; return;
        end
        if (m == 0) begin
            r = {s, 31'h0}; fo = fi; tag = "R2"; return;
        end
        sig = longint'(m);
        ex  = e;
        while (sig < 64'h80000000) begin sig = sig * 2; ex = ex - 1; end
        uf  = (ex < 0);
        tag = "R5";
        if (uf) begin
            lost = 1'b0;
            for (int k = 0; k < -ex; k++) begin
                lost = lost | sig[0];
                sig  = sig / 2;
            end
            if (lost) sig = sig | 1;
            ex = 0;
            if (sig % 256 == 0) uf = 1'b0;
            tag = "R4";
        end
        case (md)
            2'b00:   inc = ((sig / 256) % 2 == 1) ? 128 : 127;
            2'b01:   inc = s ? 0 : 255;
            2'b10:   inc = s ? 255 : 0;
            default: inc = 0;
        endcase
        if (sig + inc >= 64'h100000000) begin
            ex  = ex + 1;
            sig = (sig / 2) | (sig % 2);
            inc = inc / 2;
            tag = "R7";
        end
        ix  = (sig % 256) != 0;
        sig = sig + inc;
        if (ex >= 254) begin
            fo  = fi | 5'b10100;
            r   = (inc == 0) ? {s, 31'h7F7FFFFF} : {s, 31'h7F800000};
            tag = "R9";
        end else begin
            if (sig / 256 == 0) ex = 0;
            if (ex != 0 || sig > 64'h80000000) uf = 1'b0;
            fo = fi | {ix, uf, 3'b000};
            if (uf) tag = "R10";
            r  = pack_word(s, ex, sig / 2);
        end
    endtask

    task automatic apply(input bit s, input int e, input bit [31:0] m,
                         input bit [1:0] md, input bit [4:0] fi);
        @(negedge clk);
        sign_in  = s;
        exp_in   = EXP_W'(e);
        sig_in   = m;
        rmode_in = md;
        flags_in = fi;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input string tag, input bit [31:0] exp_r,
                         input bit [4:0] exp_f);
        checks++;
        if (!out_valid || result !== exp_r || flags_out !== exp_f) begin
            errors++;
            $display("FAIL %s: got valid=%0b result=%08h flags=%05b, expected valid=1 result=%08h flags=%05b",
                     tag, out_valid, result, flags_out, exp_r, exp_f);
        end
    endtask

    task automatic run_one(input string tag, input bit s, input int e,
                           input bit [31:0] m, input bit [1:0] md,
                           input bit [4:0] fi, input bit [31:0] exp_r,
                           input bit [4:0] exp_f);
        apply(s, e, m, md, fi);
        check(tag, exp_r, exp_f);
    endtask

    function automatic bit [31:0] pattern(int p);
        case (p)
            0:       return 32'h00000001;
            1:       return 32'h00000180;
            2:       return 32'h01000001;
            3:       return 32'h0000FFFF;
            4:       return 32'h80000080;
            5:       return 32'hFFFFFFFF;
            6:       return 32'h12345678;
            7:       return 32'h00000000;
            default: return 32'h7FFFFF80;
        endcase
    endfunction

    initial begin : watchdog
        repeat (WATCH_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected end before %0d cycles", WATCH_CYCLES);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        bit [31:0] held_r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 32'h0 || flags_out !== 5'h0) begin
            errors++;
            $display("FAIL R12 reset: got valid=%0b result=%08h flags=%05b, expected 0 0 0",
                     out_valid, result, flags_out);
        end
        rst_n = 1'b1;

        // R3: 1.0 from a small integer significand
        run_one("R3", 1'b0, 157, 32'h00000001, 2'b00, 5'b0, 32'h3F800000, 5'b00000);
        // R12: output holds, valid drops one cycle later
        held_r = result;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== held_r) begin
            errors++;
            $display("FAIL R12 hold: got valid=%0b result=%08h, expected valid=0 result=%08h",
                     out_valid, result, held_r);
        end
        // R1: infinities and flagged pass-through
        run_one("R1", 1'b1, 255, 32'h0, 2'b00, 5'b0, 32'hFF800000, 5'b00000);
        run_one("R1", 1'b0, 255, 32'h20000000, 2'b11, 5'b00001, 32'h7FC00000, 5'b00001);
        // R2: signed zero, incoming flag kept
        run_one("R2", 1'b1, 40, 32'h0, 2'b01, 5'b00010, 32'h80000000, 5'b00010);
        // R5: tie below even stays, tie above odd rounds up
        run_one("R5", 1'b0, 157, 32'h01000001, 2'b00, 5'b0, 32'h4B800000, 5'b10000);
        run_one("R5", 1'b0, 157, 32'h01000003, 2'b00, 5'b0, 32'h4B800002, 5'b10000);
        // R6: directed modes and their sign mirror
        run_one("R6", 1'b0, 157, 32'h01000001, 2'b01, 5'b0, 32'h4B800001, 5'b10000);
        run_one("R6", 1'b1, 157, 32'h01000001, 2'b01, 5'b0, 32'hCB800000, 5'b10000);
        run_one("R6", 1'b1, 157, 32'h01000001, 2'b10, 5'b0, 32'hCB800001, 5'b10000);
        run_one("R6", 1'b0, 157, 32'h01000003, 2'b11, 5'b0, 32'h4B800001, 5'b10000);
        // R7: carry-out to the next power of two
        run_one("R7", 1'b0, 157, 32'hFFFFFFFF, 2'b00, 5'b0, 32'h4F800000, 5'b10000);
        // R9: infinity versus largest finite
        run_one("R9", 1'b0, 300, 32'h80000000, 2'b00, 5'b0, 32'h7F800000, 5'b10100);
        run_one("R9", 1'b0, 300, 32'h80000000, 2'b11, 5'b0, 32'h7F7FFFFF, 5'b10100);
        run_one("R9", 1'b1, 300, 32'h80000000, 2'b01, 5'b0, 32'hFF7FFFFF, 5'b10100);
        // R4 / R10: smallest subnormal, exact and inexact
        run_one("R10", 1'b0, -24, 32'hC0000000, 2'b00, 5'b0, 32'h00000001, 5'b11000);
        run_one("R10", 1'b0, -24, 32'hC0000000, 2'b11, 5'b0, 32'h00000000, 5'b11000);
        run_one("R4", 1'b0, -23, 32'h80000000, 2'b00, 5'b0, 32'h00000001, 5'b00000);
        // R10: rounding up to the smallest normal clears underflow
        run_one("R10", 1'b0, -1, 32'hFFFFFFFF, 2'b00, 5'b0, 32'h00800000, 5'b10000);
        // R8 / R11: inexact ORed onto an incoming divide flag
        run_one("R11", 1'b0, 157, 32'h01000001, 2'b00, 5'b00010, 32'h4B800000, 5'b10010);
        run_one("R8", 1'b0, 157, 32'h00000003, 2'b00, 5'b0, 32'h40400000, 5'b00000);

        // sweep across exponent ranges, patterns, modes and signs
        for (int e = -60; e <= 290; e++) begin
            for (int p = 0; p < 9; p++) begin
                for (int md = 0; md < 4; md++) begin
                    for (int s = 0; s < 2; s++) begin
                        bit [31:0] er;
                        bit [4:0]  ef;
                        bit [4:0]  fi;
                        string     tg;
                        fi = (e % 3 == 0) ? 5'b00010 : 5'b00000;
                        ref_model(s[0], e, pattern(p), md[1:0], fi, er, ef, tg);
                        run_one(tg, s[0], e, pattern(p), md[1:0], fi, er, ef);
                    end
                end
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule